// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block gathers every reset request in the chip and turns them into two kinds of reset: a power-on reset and a manual reset. Each logic domain gets its own reset output. The CPU core and the interrupt register-bank bit are reset by either kind. The floating-point unit, the on-chip peripheral and I/O port registers, and the watchdog and clock-control registers are reset only by a power-on reset. A manual reset therefore restarts the processor but keeps the configuration those domains hold.

There are four request sources:

- an active-low external power-on pin, which overrides everything else;
- a reset-assert command from the debug interface, which gives a power-on reset;
- an active-low manual reset pin;
- a watchdog overflow pulse, whose reset kind is chosen by a configuration input.

The two pins are asynchronous. Each goes through a two-flop bridge, so a domain reset asserts without waiting for a clock and releases on a clock edge. Once triggered, a reset stays on for a fixed hold time after its last request goes away. A two-bit cause register reports which source was granted most recently.

Top module: `rstc_top`

## Requirements
- R1: While `por_n_i` is low, all five reset outputs are high. They rise without waiting for a clock edge, and `dbg_rst_i`, `wdt_ovf_i` and `mres_n_i` have no effect.
- R2: After `por_n_i` returns high, every output stays high at SYNC_STAGES + HOLD_CYCLES = 18 consecutive falling-edge samples, counted from the sample taken just after the pin rises. All outputs are low at the next sample.
- R3: `dbg_rst_i` sampled high at a rising edge gives a power-on reset: all five outputs are high after that edge.
- R4: A manual reset drives `rst_cpu_o` and `rst_ibank_o` high. It leaves `rst_fpu_o`, `rst_periph_o` and `rst_wdtclk_o` low.
- R5: `mres_n_i` low asserts `rst_cpu_o` at once. After the pin is released, `rst_cpu_o` stays high for 18 falling-edge samples.
- R6: `wdt_ovf_i` sampled high gives a power-on reset when `wdt_type_i` is 1 and a manual reset when it is 0. In both cases the hold after a one-cycle pulse lasts 16 samples.
- R7: When requests coincide, the power-on kind is applied. `cause_o` takes the winner, in this priority: pin power-on (0), debug (1), watchdog with power-on type (3), manual pin (2), watchdog with manual type (3).
- R8: A reset request extends the hold. Outputs stay high for HOLD_CYCLES = 16 cycles after the last cycle in which a request was sampled.
- R9: `cause_o` reads 0 after a pin power-on reset. It keeps its value while no request is present, and no other source can set it to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| por_n_i | input | 1 | External power-on pin, active low, asynchronous |
| mres_n_i | input | 1 | Manual reset pin, active low, asynchronous |
| dbg_rst_i | input | 1 | Debug reset-assert command, synchronous level |
| wdt_ovf_i | input | 1 | Watchdog overflow pulse, synchronous |
| wdt_type_i | input | 1 | Watchdog reset kind: 1 power-on, 0 manual |
| rst_cpu_o | output | 1 | CPU core reset, active high |
| rst_fpu_o | output | 1 | Floating-point unit reset, active high |
| rst_periph_o | output | 1 | Peripheral and I/O port register reset, active high |
| rst_wdtclk_o | output | 1 | Watchdog and clock-control register reset, active high |
| rst_ibank_o | output | 1 | Interrupt register-bank bit reset, active high |
| cause_o | output | 2 | Last granted cause: 0 pin, 1 debug, 2 manual pin, 3 watchdog |

## Verification
The hardest case to reach from the ports is two sources active in the same cycle, where the reset kind and the cause must each follow their own rule. The stimulus holds the manual pin low while the debug command, or a watchdog pulse of either type, arrives in the same clock period. Cause and domain outputs are then sampled while both requests are still present. The hold is also retriggered partway through its count, to show that the window restarts from the latest request rather than from the first.

// File: rtl/rstc_pkg.sv
package rstc_pkg;

    typedef enum logic [1:0] {
        CAUSE_PIN    = 2'd0,
        CAUSE_DEBUG  = 2'd1,
        CAUSE_MANUAL = 2'd2,
        CAUSE_WDT    = 2'd3
    } cause_e;

    typedef struct packed {
        logic   por;    // power-on kind requested this cycle
        logic   man;    // manual kind requested this cycle
        logic   valid;  // any request present
        cause_e cause;  // winning source
    } grant_t;

    localparam int NUM_PINS  = 2;
    localparam int PIN_POR   = 0;
    localparam int PIN_MAN   = 1;
    localparam int NUM_KINDS = 2;
    localparam int KIND_POR  = 0;
    localparam int KIND_MAN  = 1;

    function automatic grant_t arbitrate(input logic pin_req,
                                         input logic dbg_req,
                                         input logic wdt_ovf,
                                         input logic wdt_type,
                                         input logic man_req);
        grant_t g;
        g.por   = pin_req | dbg_req | (wdt_ovf & wdt_type);
        g.man   = man_req | (wdt_ovf & ~wdt_type);
        g.valid = g.por | g.man;
        if (pin_req)                    g.cause = CAUSE_PIN;
        else if (dbg_req)               g.cause = CAUSE_DEBUG;
        else if (wdt_ovf && wdt_type)   g.cause = CAUSE_WDT;
        else if (man_req)               g.cause = CAUSE_MANUAL;
        else if (wdt_ovf)               g.cause = CAUSE_WDT;
        else                            g.cause = CAUSE_PIN;
        return g;
    endfunction

endpackage

// File: rtl/rstc_sync_bridge.sv
module rstc_sync_bridge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic pin_n_i,
    output logic req_o
);
    logic [STAGES-1:0] stage_q;

    // Request asserts as soon as the pin falls, clears STAGES edges after it rises.
    always_ff @(posedge clk or negedge pin_n_i) begin
        if (!pin_n_i) stage_q <= '1;
        else          stage_q <= {stage_q[STAGES-2:0], 1'b0};
    end

    assign req_o = stage_q[STAGES-1];
endmodule

// File: rtl/rstc_arbiter.sv
module rstc_arbiter
    import rstc_pkg::*;
(
    input  logic   pin_req_i,
    input  logic   dbg_req_i,
    input  logic   wdt_ovf_i,
    input  logic   wdt_type_i,
    input  logic   man_req_i,
    output grant_t grant_o
);
    always_comb begin
        grant_o = arbitrate(pin_req_i, dbg_req_i, wdt_ovf_i, wdt_type_i, man_req_i);
    end
endmodule

// File: rtl/rstc_hold.sv
module rstc_hold #(
    parameter int HOLD = 16
) (
    input  logic clk,
    input  logic clr_i,
    input  logic load_i,
    output logic active_o
);
    localparam int CW = $clog2(HOLD + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (clr_i)               cnt_q <= '0;
        else if (load_i)         cnt_q <= CW'(HOLD);
        else if (cnt_q != '0)    cnt_q <= cnt_q - CW'(1);
    end

    assign active_o = (cnt_q != '0);
endmodule

// File: rtl/rstc_top.sv
module rstc_top
    import rstc_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int HOLD_CYCLES = 16
) (
    input  logic       clk,
    input  logic       por_n_i,
    input  logic       mres_n_i,
    input  logic       dbg_rst_i,
    input  logic       wdt_ovf_i,
    input  logic       wdt_type_i,
    output logic       rst_cpu_o,
    output logic       rst_fpu_o,
    output logic       rst_periph_o,
    output logic       rst_wdtclk_o,
    output logic       rst_ibank_o,
    output logic [1:0] cause_o
);
    logic [NUM_PINS-1:0]  pin_n_vec;
    logic [NUM_PINS-1:0]  pin_req_vec;
    logic [NUM_KINDS-1:0] kind_load;
    logic [NUM_KINDS-1:0] kind_clr;
    logic [NUM_KINDS-1:0] kind_active;
    logic                 pin_req;
    logic                 man_req;
    grant_t               grant;
    cause_e               cause_q;
    logic                 por_dom;
    logic                 cpu_dom;

    assign pin_n_vec[PIN_POR] = por_n_i;
    assign pin_n_vec[PIN_MAN] = mres_n_i;

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_bridge
        rstc_sync_bridge #(.STAGES(SYNC_STAGES)) bridge_i (
            .clk     (clk),
            .pin_n_i (pin_n_vec[g]),
            .req_o   (pin_req_vec[g])
        );
    end

    assign pin_req = pin_req_vec[PIN_POR];
    assign man_req = pin_req_vec[PIN_MAN];

    rstc_arbiter arb_i (
        .pin_req_i  (pin_req),
        .dbg_req_i  (dbg_rst_i),
        .wdt_ovf_i  (wdt_ovf_i),
        .wdt_type_i (wdt_type_i),
        .man_req_i  (man_req),
        .grant_o    (grant)
    );

    assign kind_load[KIND_POR] = grant.por;
    assign kind_load[KIND_MAN] = grant.man;
    assign kind_clr[KIND_POR]  = 1'b0;
    assign kind_clr[KIND_MAN]  = pin_req;

    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_hold
        rstc_hold #(.HOLD(HOLD_CYCLES)) hold_i (
            .clk      (clk),
            .clr_i    (kind_clr[k]),
            .load_i   (kind_load[k]),
            .active_o (kind_active[k])
        );
    end

    // Cause register: the pin request is the synchronous clear.
    always_ff @(posedge clk) begin
        if (pin_req)          cause_q <= CAUSE_PIN;
        else if (grant.valid) cause_q <= grant.cause;
    end

    assign por_dom = pin_req | kind_active[KIND_POR];
    assign cpu_dom = por_dom | man_req | kind_active[KIND_MAN];

    assign rst_cpu_o    = cpu_dom;
    assign rst_ibank_o  = cpu_dom;
    assign rst_fpu_o    = por_dom;
    assign rst_periph_o = por_dom;
    assign rst_wdtclk_o = por_dom;
    assign cause_o      = cause_q;
endmodule

// File: rtl/rstc_checker.sv
module rstc_checker
    import rstc_pkg::*;
#(
    parameter int HOLD_CYCLES = 16
) (
    input logic       clk,
    input logic       por_n_i,
    input logic       dbg_rst_i,
    input logic       wdt_ovf_i,
    input logic       wdt_type_i,
    input logic       rst_cpu_o,
    input logic       rst_fpu_o,
    input logic       rst_periph_o,
    input logic       rst_wdtclk_o,
    input logic       rst_ibank_o,
    input logic [1:0] cause_o,
    input logic       pin_req,
    input logic       man_req
);
    localparam int SW = $clog2(HOLD_CYCLES + 1) + 1;

    logic          started;
    logic [SW-1:0] since_por;
    logic          por_seen;

    initial started = 1'b0;
    always @(posedge clk) started <= 1'b1;

    assign por_seen = pin_req | dbg_rst_i | (wdt_ovf_i & wdt_type_i);

    always @(posedge clk) begin
        if (por_seen)                         since_por <= '0;
        else if (since_por < SW'(HOLD_CYCLES)) since_por <= since_por + SW'(1);
    end

    always @(negedge clk) begin
        if (started && !por_n_i) begin
            assert_pin_all_R1: assert (rst_cpu_o && rst_fpu_o && rst_periph_o &&
                                       rst_wdtclk_o && rst_ibank_o);
        end
    end

    assert_dbg_por_R3: assert property (@(posedge clk) disable iff (pin_req)
        dbg_rst_i |=> (rst_fpu_o && rst_periph_o && rst_wdtclk_o && rst_cpu_o));

    assert_kind_nesting_R4: assert property (@(posedge clk) disable iff (pin_req)
        (rst_fpu_o || rst_periph_o) |-> (rst_cpu_o && rst_ibank_o));

    assert_wdt_kind_R6: assert property (@(posedge clk) disable iff (pin_req)
        (wdt_ovf_i && wdt_type_i) |=> rst_fpu_o);

    assert_wdt_cpu_R6: assert property (@(posedge clk) disable iff (pin_req)
        wdt_ovf_i |=> rst_cpu_o);

    assert_dbg_cause_R7: assert property (@(posedge clk) disable iff (pin_req)
        dbg_rst_i |=> (cause_o == CAUSE_DEBUG));

    assert_hold_len_R8: assert property (@(posedge clk) disable iff (pin_req)
        $fell(rst_fpu_o) |-> (since_por >= SW'(HOLD_CYCLES)));

    assert_cause_keep_R9: assert property (@(posedge clk) disable iff (pin_req)
        (!dbg_rst_i && !wdt_ovf_i && !man_req) |=> $stable(cause_o));
endmodule

bind rstc_top rstc_checker #(.HOLD_CYCLES(HOLD_CYCLES)) chk_i (.*);

// File: tb/rstc_top_tb_top.sv
module rstc_top_tb_top;
    logic       clk = 1'b0;
    logic       por_n = 1'b1;
    logic       mres_n = 1'b1;
    logic       dbg = 1'b0;
    logic       ovf = 1'b0;
    logic       wtype = 1'b0;
    logic       r_cpu, r_fpu, r_per, r_wdc, r_ibk;
    logic [1:0] cause;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rstc_top dut_i (
        .clk          (clk),
        .por_n_i      (por_n),
        .mres_n_i     (mres_n),
        .dbg_rst_i    (dbg),
        .wdt_ovf_i    (ovf),
        .wdt_type_i   (wtype),
        .rst_cpu_o    (r_cpu),
        .rst_fpu_o    (r_fpu),
        .rst_periph_o (r_per),
        .rst_wdtclk_o (r_wdc),
        .rst_ibank_o  (r_ibk),
        .cause_o      (cause)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input int act, input int exp);
        chk(act == exp, req, act, exp);
    endtask

    function automatic int all_por();
        return {29'd0, r_fpu, r_per, r_wdc} == 3'b111 ? 1 : 0;
    endfunction

    // Counts falling-edge samples while the chosen output is high (sel 0: fpu, 1: cpu).
    task automatic count_high(input int sel, output int n);
        n = 0;
        while ((sel == 0 ? r_fpu : r_cpu) && n < 100) begin
            n++;
            @(negedge clk); #1;
        end
    endtask

    task automatic settle();
        int n;
        count_high(1, n);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_power_on();
        int n;
        @(negedge clk); #1;
        por_n = 1'b0;
        dbg = 1'b1;
        mres_n = 1'b0;
        #1;
        chk_eq("R1 async all outputs", {r_cpu, r_fpu, r_per, r_wdc, r_ibk}, 5'b11111);
        repeat (4) @(negedge clk);
        #1;
        chk_eq("R1 held during pin", {r_cpu, r_fpu, r_per, r_wdc, r_ibk}, 5'b11111);
        chk_eq("R9 cause after pin", cause, 0);
        dbg = 1'b0;
        mres_n = 1'b1;
        @(negedge clk);
        por_n = 1'b1;
        #1;
        count_high(0, n);
        chk_eq("R2 release length", n, 18);
        chk_eq("R2 all low after", {r_cpu, r_fpu, r_per, r_wdc, r_ibk}, 5'b00000);
        chk_eq("R9 cause kept 0", cause, 0);
    endtask

    task automatic t_debug();
        int n;
        settle();
        dbg = 1'b1;
        @(negedge clk); #1;
        chk_eq("R3 debug gives power-on", all_por() & int'(r_cpu) & int'(r_ibk), 1);
        chk_eq("R7 cause debug", cause, 1);
        @(negedge clk);
        @(negedge clk);
        dbg = 1'b0;
        #1;
        count_high(0, n);
        chk_eq("R8 hold after debug", n, 16);
    endtask

    task automatic t_manual();
        int n;
        int fpu_seen;
        settle();
        mres_n = 1'b0;
        #1;
        chk_eq("R5 manual async cpu", {r_cpu, r_ibk}, 2'b11);
        chk_eq("R4 manual spares domains", {r_fpu, r_per, r_wdc}, 3'b000);
        repeat (3) @(negedge clk);
        #1;
        chk_eq("R7 cause manual", cause, 2);
        chk_eq("R4 manual spares held", {r_fpu, r_per, r_wdc}, 3'b000);
        @(negedge clk);
        mres_n = 1'b1;
        #1;
        fpu_seen = 0;
        n = 0;
        while (r_cpu && n < 100) begin
            if (r_fpu || r_per || r_wdc) fpu_seen = 1;
            n++;
            @(negedge clk); #1;
        end
        chk_eq("R5 manual release length", n, 18);
        chk_eq("R4 domains never set", fpu_seen, 0);
    endtask

    task automatic t_wdt();
        int n;
        settle();
        wtype = 1'b1;
        ovf = 1'b1;
        @(negedge clk);
        ovf = 1'b0;
        #1;
        chk_eq("R6 wdt power-on domains", all_por(), 1);
        chk_eq("R6 wdt cause", cause, 3);
        count_high(0, n);
        chk_eq("R6 wdt power-on hold", n, 16);
        settle();
        wtype = 1'b0;
        ovf = 1'b1;
        @(negedge clk);
        ovf = 1'b0;
        #1;
        chk_eq("R6 wdt manual kind", {r_cpu, r_ibk, r_fpu, r_per, r_wdc}, 5'b11000);
        chk_eq("R6 wdt manual cause", cause, 3);
        count_high(1, n);
        chk_eq("R6 wdt manual hold", n, 16);
    endtask

    task automatic t_simultaneous();
        settle();
        dbg = 1'b1;
        mres_n = 1'b0;
        @(negedge clk); #1;
        chk_eq("R7 debug+manual applies power-on", all_por(), 1);
        chk_eq("R7 debug beats manual cause", cause, 1);
        dbg = 1'b0;
        mres_n = 1'b1;
        settle();
        mres_n = 1'b0;
        wtype = 1'b1;
        ovf = 1'b1;
        @(negedge clk);
        ovf = 1'b0;
        #1;
        chk_eq("R7 wdt-por beats manual cause", cause, 3);
        chk_eq("R7 wdt-por+manual applies power-on", all_por(), 1);
        settle();
        wtype = 1'b0;
        ovf = 1'b1;
        @(negedge clk);
        ovf = 1'b0;
        #1;
        chk_eq("R7 manual beats wdt-manual cause", cause, 2);
        mres_n = 1'b1;
        settle();
    endtask

    task automatic t_retrigger();
        int n;
        settle();
        dbg = 1'b1;
        @(negedge clk);
        dbg = 1'b0;
        repeat (8) @(negedge clk);
        #1;
        chk_eq("R8 mid-hold still high", int'(r_fpu), 1);
        dbg = 1'b1;
        @(negedge clk);
        dbg = 1'b0;
        #1;
        count_high(0, n);
        chk_eq("R8 retrigger restarts hold", n, 16);
    endtask

    task automatic t_cause_keep();
        settle();
        mres_n = 1'b0;
        @(negedge clk);
        mres_n = 1'b1;
        settle();
        repeat (20) @(negedge clk);
        #1;
        chk_eq("R9 cause retained idle", cause, 2);
        por_n = 1'b0;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        settle();
        #1;
        chk_eq("R9 pin clears cause", cause, 0);
    endtask

    initial begin
        #1;
        t_power_on();
        t_debug();
        t_manual();
        t_wdt();
        t_simultaneous();
        t_retrigger();
        t_cause_keep();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule